// File: doc/BRIEF.md
# Read-Sequence-Cleared Packet Statistics Counters

This block keeps packet statistics for the two directions of a physical-layer device. Each direction counts good packets in a wide counter and errored packets in a narrower one. A packet arrives as a single-cycle strobe with an error flag beside it. An errored packet counts only as an error, and every counter stops at its maximum value instead of wrapping.

Software reads six consecutive registers through a simple read port. The first three registers belong to the transmit group and the last three to the receive group. Within a group, the first register gives the low half of the good count, the second gives the upper part, and the third gives the error count. Reading the first register of a group freezes that group: its visible values stop moving, and new events collect in a hidden shadow accumulator. The group is cleared only if the next two reads of that group are its second and then its third register. Once the group is released, whether by the clearing read or by an out-of-order read, the shadow is folded back in, so no event is lost.

Top module: `pkt_stat_counters`

## Requirements
- R1: The registers are at BASE_ADDR+0 to BASE_ADDR+5. Offsets 0, 1 and 2 are the transmit group and offsets 3, 4 and 5 are the receive group. Within a group, offset 0 returns good count bits REG_W-1:0, offset 1 returns the good count bits above REG_W (zero-extended), and offset 2 returns the error count (zero-extended). `rd_data` is loaded on the clock edge that samples `rd_en`.
- R2: A strobe with its error flag low adds one to that direction's good count. A strobe with the flag high adds one to the error count only.
- R3: Reading a group's offsets 0, 1 and 2 in that order, with no other read of that group in between, clears the group's counters. The read of offset 2 still returns the count from before the clear.
- R4: A read of a group's offset 0 while the group is idle freezes the group. Events that arrive while it is frozen do not change the values it returns.
- R5: Any other read of a group while it is frozen or idle is a deviation. This includes a second read of offset 0. A deviation releases the group without clearing it and returns the tracker to idle, and the deviating read does not start a new sequence. The order 0,1,0,1,2 therefore leaves the counts intact.
- R6: Events that arrive while a group is frozen are added to its counters when the group is released. After a clear, the counters hold exactly those events.
- R7: Every counter, and every shadow accumulator, saturates at all ones.
- R8: A read of one group does not affect the sequence of the other group. A read outside the six-register window returns 0 and affects no group.
- R9: After reset, all counts are 0, both groups are idle and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_pkt_stb | input | 1 | One transmit packet completed |
| tx_pkt_err | input | 1 | The transmit packet was errored |
| rx_pkt_stb | input | 1 | One receive packet completed |
| rx_pkt_err | input | 1 | The receive packet was errored |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | REG_W | Read data, registered |

## Verification
The bench builds the block with REG_W=8, PKT_W=12, ERR_W=4, ADDR_W=4 and BASE_ADDR=4. The narrow register width makes the split of the good count across two registers visible with a few hundred packets. The small counter widths let both good-count and error-count saturation be reached within a few thousand cycles. The non-zero base address leaves room below and above the window, so the bench can issue reads that miss it.

// File: rtl/pkt_stat_pkg.sv
package pkt_stat_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_GOT0 = 2'd1,
        SEQ_GOT1 = 2'd2
    } seq_state_e;

    localparam int REGS_PER_GROUP = 3;
    localparam int NUM_GROUPS     = 2;
endpackage

// File: rtl/stat_seq_tracker.sv
module stat_seq_tracker
    import pkt_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_hit,
    input  logic [1:0] rd_idx,
    output logic       hold,
    output logic       clr,
    output logic       frozen
);
    typedef struct packed {
        seq_state_e st;
    } trk_t;

    trk_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        clr   = 1'b0;
        if (rd_hit) begin
            unique case (rd_idx)
                2'd0: nxt_d.st = (cur_q.st == SEQ_IDLE) ? SEQ_GOT0 : SEQ_IDLE;
                2'd1: nxt_d.st = (cur_q.st == SEQ_GOT0) ? SEQ_GOT1 : SEQ_IDLE;
                default: begin
                    clr      = (cur_q.st == SEQ_GOT1);
                    nxt_d.st = SEQ_IDLE;
                end
            endcase
        end
        hold   = (nxt_d.st != SEQ_IDLE);
        frozen = (cur_q.st != SEQ_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: SEQ_IDLE};
        else        cur_q <= nxt_d;
    end

    // R5: a repeated first read while frozen ends the sequence
    p_deviation_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && rd_idx == 2'd0 && cur_q.st != SEQ_IDLE) |=> (cur_q.st == SEQ_IDLE));
endmodule

// File: rtl/sat_accum.sv
module sat_accum #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         hold,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV     = {W{1'b1}};
    localparam logic [W+1:0] MAXV_EXT = {2'b00, MAXV};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] shadow;
    } acc_t;

    acc_t acc_q, acc_d;
    logic [W+1:0] sum;
    logic [W-1:0] base;

    always_comb begin
        acc_d = acc_q;
        base  = clr ? '0 : acc_q.cnt;
        if (hold) begin
            sum = {2'b00, acc_q.shadow} + (W+2)'(inc);
            acc_d.shadow = (sum > MAXV_EXT) ? MAXV : sum[W-1:0];
        end else begin
            sum = {2'b00, base} + {2'b00, acc_q.shadow} + (W+2)'(inc);
            acc_d.cnt    = (sum > MAXV_EXT) ? MAXV : sum[W-1:0];
            acc_d.shadow = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign cnt = acc_q.cnt;

    // R7: a full counter that is not cleared stays full
    p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q.cnt == MAXV && !clr) |=> (acc_q.cnt == MAXV));
endmodule

// File: rtl/stat_group.sv
module stat_group #(
    parameter int PKT_W = 32,
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_stb,
    input  logic             pkt_err,
    input  logic             rd_hit,
    input  logic [1:0]       rd_idx,
    output logic [PKT_W-1:0] good_cnt,
    output logic [ERR_W-1:0] err_cnt
);
    logic hold, clr, frozen;
    logic good_inc, err_inc;

    assign good_inc = pkt_stb && !pkt_err;
    assign err_inc  = pkt_stb && pkt_err;

    stat_seq_tracker trk_i (
        .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .rd_idx(rd_idx),
        .hold(hold), .clr(clr), .frozen(frozen)
    );

    sat_accum #(.W(PKT_W)) good_i (
        .clk(clk), .rst_n(rst_n), .inc(good_inc), .hold(hold), .clr(clr), .cnt(good_cnt)
    );

    sat_accum #(.W(ERR_W)) err_i (
        .clk(clk), .rst_n(rst_n), .inc(err_inc), .hold(hold), .clr(clr), .cnt(err_cnt)
    );

    // R4: visible values do not move while the tracker stays frozen
    p_freeze_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frozen) && frozen) |-> ($stable(good_cnt) && $stable(err_cnt)));
endmodule

// File: rtl/pkt_stat_counters.sv
module pkt_stat_counters
    import pkt_stat_pkg::*;
#(
    parameter int REG_W     = 16,
    parameter int PKT_W     = 32,
    parameter int ERR_W     = 16,
    parameter int ADDR_W    = 12,
    parameter int BASE_ADDR = 299
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_pkt_stb,
    input  logic              tx_pkt_err,
    input  logic              rx_pkt_stb,
    input  logic              rx_pkt_err,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data
);
    localparam int NUM_REGS = NUM_GROUPS * REGS_PER_GROUP;

    typedef struct packed {
        logic [REG_W-1:0] rdata;
    } top_t;

    logic [PKT_W-1:0] good_cnt [NUM_GROUPS];
    logic [ERR_W-1:0] err_cnt  [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] stb, err, grp_hit;
    logic       hit;
    logic       sel_grp;
    logic [1:0] sel_idx;
    top_t cur_q, nxt_d;

    assign stb = {rx_pkt_stb, tx_pkt_stb};
    assign err = {rx_pkt_err, tx_pkt_err};

    always_comb begin
        hit     = 1'b0;
        sel_grp = 1'b0;
        sel_idx = 2'd0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_addr == ADDR_W'(BASE_ADDR + k)) begin
                hit     = 1'b1;
                sel_grp = 1'(k / REGS_PER_GROUP);
                sel_idx = 2'(k % REGS_PER_GROUP);
            end
        end
        for (int g = 0; g < NUM_GROUPS; g++)
            grp_hit[g] = rd_en && hit && (sel_grp == 1'(g));
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        stat_group #(.PKT_W(PKT_W), .ERR_W(ERR_W)) grp_i (
            .clk(clk), .rst_n(rst_n),
            .pkt_stb(stb[g]), .pkt_err(err[g]),
            .rd_hit(grp_hit[g]), .rd_idx(sel_idx),
            .good_cnt(good_cnt[g]), .err_cnt(err_cnt[g])
        );
    end

    always_comb begin
        nxt_d = cur_q;
        if (rd_en) begin
            if (!hit)                nxt_d.rdata = '0;
            else if (sel_idx == 2'd0) nxt_d.rdata = good_cnt[sel_grp][REG_W-1:0];
            else if (sel_idx == 2'd1) nxt_d.rdata = REG_W'(good_cnt[sel_grp] >> REG_W);
            else                      nxt_d.rdata = REG_W'(err_cnt[sel_grp]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rd_data = cur_q.rdata;

    // R8: a read outside the window returns zero
    p_outside_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |=> (rd_data == '0));

    // R1: read data only changes on a read
    p_data_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/pkt_stat_counters_tb_top.sv
module pkt_stat_counters_tb_top;
    localparam int REG_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_pkt_stb = 0, tx_pkt_err = 0, rx_pkt_stb = 0, rx_pkt_err = 0;
    logic rd_en = 0;
    logic [3:0] rd_addr = '0;
    logic [REG_W-1:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        int    exp;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    pkt_stat_counters #(.REG_W(8), .PKT_W(12), .ERR_W(4), .ADDR_W(4), .BASE_ADDR(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_pkt_stb(tx_pkt_stb), .tx_pkt_err(tx_pkt_err),
        .rx_pkt_stb(rx_pkt_stb), .rx_pkt_err(rx_pkt_err),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // driver: one read, expected value queued for the monitor
    task automatic rd(input int a, input int exp, input string tag);
        exp_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = 4'(a);
        @(negedge clk);
        rd_en   = 1'b0;
    endtask

    task automatic pkts(input bit rx, input bit e, input int n);
        @(negedge clk);
        if (rx) begin rx_pkt_stb = 1'b1; rx_pkt_err = e; end
        else    begin tx_pkt_stb = 1'b1; tx_pkt_err = e; end
        repeat (n) @(negedge clk);
        tx_pkt_stb = 0; tx_pkt_err = 0; rx_pkt_stb = 0; rx_pkt_err = 0;
    endtask

    // monitor: pops one expected item per sampled read
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    check(1, 0, "R1 unexpected read data");
                end else begin
                    exp_t it;
                    it = sb_q.pop_front();
                    check(int'(rd_data), it.exp, it.tag);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(0, 1, "watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(rd_data), 0, "R9 rd_data after reset");
        for (int a = 4; a < 10; a++) rd(a, 0, "R9 counts zero after reset");

        // R2 counting and R1 layout, then R3 clear
        pkts(0, 0, 5); pkts(0, 1, 3); pkts(1, 0, 300); pkts(1, 1, 2);
        rd(4, 5, "R2 tx good low"); rd(5, 0, "R1 tx good high"); rd(6, 3, "R2 tx err only");
        rd(4, 0, "R3 tx cleared low"); rd(5, 0, "R3 tx cleared high"); rd(6, 0, "R3 tx err cleared");
        rd(7, 44, "R1 rx good low byte"); rd(8, 1, "R1 rx good high part"); rd(9, 2, "R2 rx err");
        rd(7, 0, "R3 rx cleared"); rd(8, 0, "R3 rx cleared"); rd(9, 0, "R3 rx cleared");

        // R4 and R6: events during freeze survive the clear
        pkts(0, 0, 10);
        rd(4, 10, "R4 freeze read");
        pkts(0, 0, 7);
        rd(5, 0, "R4 frozen high"); rd(6, 0, "R3 clearing read");
        rd(4, 7, "R6 frozen events kept after clear"); rd(5, 0, "R6 high"); rd(6, 0, "R6 err");

        // R5 deviation by re-reading offset 0
        pkts(0, 0, 3);
        rd(4, 3, "R4 freeze");
        pkts(0, 0, 4);
        rd(4, 3, "R4 value frozen on re-read");
        rd(5, 0, "R5 deviation high"); rd(6, 0, "R5 deviation err");
        rd(4, 7, "R5 not cleared, R6 merged");
        rd(5, 0, "R3 seq"); rd(6, 0, "R3 seq");
        rd(4, 0, "R3 cleared after proper seq"); rd(5, 0, "R3 close"); rd(6, 0, "R3 close");

        // R5 pattern 0,1,0,1,2 on rx
        pkts(1, 0, 20);
        rd(7, 20, "R5 p1"); rd(8, 0, "R5 p2"); rd(7, 20, "R5 p3"); rd(8, 0, "R5 p4"); rd(9, 0, "R5 p5");
        rd(7, 20, "R5 pattern did not clear"); rd(8, 0, "R5 seq"); rd(9, 0, "R5 seq");
        rd(7, 0, "R3 rx cleared"); rd(8, 0, "R3 rx"); rd(9, 0, "R3 rx");

        // R8 interleaved group and out-of-window reads
        pkts(0, 0, 2);
        rd(4, 2, "R8 tx start"); rd(7, 0, "R8 rx read"); rd(5, 0, "R8 tx mid");
        rd(9, 0, "R8 rx deviation"); rd(6, 0, "R8 tx end");
        rd(4, 0, "R8 tx cleared despite rx reads"); rd(5, 0, "R8"); rd(6, 0, "R8");
        pkts(0, 0, 6);
        rd(4, 6, "R8 tx start"); rd(0, 0, "R8 below window zero"); rd(15, 0, "R8 above window zero");
        rd(5, 0, "R8 tx mid"); rd(6, 0, "R8 tx end");
        rd(4, 0, "R8 cleared despite outside reads"); rd(5, 0, "R8"); rd(6, 0, "R8");

        // R7 saturation
        pkts(0, 1, 20); pkts(0, 0, 4100);
        rd(4, 255, "R7 good low saturated"); rd(5, 15, "R7 good high saturated");
        rd(6, 15, "R7 err saturated");
        rd(4, 0, "R7 clear after saturation"); rd(5, 0, "R7"); rd(6, 0, "R7");

        repeat (4) @(negedge clk);
        check(sb_q.size(), 0, "R1 all reads answered");
        finish_run();
    end
endmodule